// File: doc/BRIEF.md
# Memory Fault Status Capture

This block records what went wrong when a data memory access faults. A fault strobe, raised by translation logic outside the block, loads three registers that software can read. The first holds the whole faulting virtual address. The second is a status word that packs the opcode of the faulting instruction, its destination register number and a vector of fault cause flags. The third is a formatted address that points at the page table entry for the faulting page: the page table base ORed with the virtual page number scaled by eight.

After a capture the three registers are frozen. Software first reads the status and the formatted address, then reads the address register. That read releases the freeze, so a later fault can be recorded. Accesses marked as misspeculated never touch the registers. The block does not decide when a fault has happened. It only records one when it is told.

Top module: `mmfault_capture`

## Requirements
- R1: After reset, the address register, the status register and the formatted address register all read zero, and the registers are unfrozen.
- R2: On a capture, the status register takes the opcode in bits 16:11, the destination register number in bits 10:6 and the fault flags in bits 5:0. The flag bits are: bit0 write, bit1 access violation, bit2 fault on read, bit3 fault on write, bit4 translation miss, bit5 bad virtual address.
- R3: On a capture, the address register takes the full faulting virtual address.
- R4: On a capture, the formatted address register takes the page table base ORed with the virtual page number shifted left by 3. The virtual page number is the virtual address above the 13-bit page offset.
- R5: A fault strobe with the misspeculation flag set changes no register and does not freeze them.
- R6: Once a capture has happened, later fault strobes change no register until the address register is read.
- R7: A read of the address register unfreezes the registers in that same cycle, so a fault strobe in the very next cycle is captured.
- R8: A fault strobe in the same cycle as an address-register read, while the registers are frozen, is dropped.
- R9: A fault strobe in the same cycle as an address-register read, while the registers are unfrozen, is captured and leaves the registers frozen.
- R10: The registers show a captured fault right after the clock edge that samples the strobe; there is no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all registers and the freeze |
| flt_strobe | input | 1 | A data access faulted in this cycle |
| flt_vaddr | input | VA_W (43) | Virtual address of the faulting access |
| flt_flags | input | 6 | Fault cause flags, using the bit assignment in R2 |
| flt_opcode | input | 6 | Opcode of the faulting instruction |
| flt_dest | input | 5 | Destination register number of the faulting instruction |
| flt_squashed | input | 1 | The faulting access is misspeculated |
| pt_base | input | FMT_W (64) | Page table base used to form the entry address |
| va_rd | input | 1 | Software reads the address register in this cycle |
| va_reg | output | VA_W (43) | Captured faulting virtual address |
| stat_reg | output | 17 | Captured status word |
| pte_addr_reg | output | FMT_W (64) | Captured page table entry address |

## Verification
The freeze state is not brought out to the ports, so an error in it can only be seen through which strobes get captured. A freeze that stays set too long shows up as a lost capture on the first strobe after a read. A freeze that is never set shows up as registers overwritten by the next strobe. Either one appears one clock edge after the strobe that should or should not have been taken. The bench therefore follows every read or strobe that could flip the freeze with another strobe carrying a different address, and checks the registers just after that edge. A packing error in the status or the formatted address shows at the first capture. Flag patterns with distinct bits set, and addresses whose page number overlaps set bits of the base, tell the fields apart.

// File: rtl/mmf_pkg.sv
package mmf_pkg;

  localparam int OPC_W   = 6;
  localparam int RNUM_W  = 5;
  localparam int FLG_W   = 6;
  localparam int STAT_W  = OPC_W + RNUM_W + FLG_W;

  // field positions inside the status word (software decodes these)
  localparam int FLG_LSB  = 0;
  localparam int RNUM_LSB = FLG_LSB + FLG_W;
  localparam int OPC_LSB  = RNUM_LSB + RNUM_W;

  // fault cause flag bit indices
  localparam int FLG_WRITE = 0;
  localparam int FLG_ACV   = 1;
  localparam int FLG_FOR   = 2;
  localparam int FLG_FOW   = 3;
  localparam int FLG_MISS  = 4;
  localparam int FLG_BADVA = 5;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [RNUM_W-1:0] rnum;
    logic [FLG_W-1:0]  flags;
  } fault_info_t;

  // place each field at its offset in the status word
  function automatic logic [STAT_W-1:0] pack_status(input fault_info_t fi);
    logic [STAT_W-1:0] w;
    w = '0;
    w = w | (STAT_W'(fi.opc)   << OPC_LSB);
    w = w | (STAT_W'(fi.rnum)  << RNUM_LSB);
    w = w | (STAT_W'(fi.flags) << FLG_LSB);
    return w;
  endfunction

endpackage

// File: rtl/mmf_lock_ctl.sv
module mmf_lock_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic squashed,
  input  logic va_rd,
  output logic capture_en,
  output logic lock_q
);

  logic lock_d;

  // a capture needs a real, non-speculative fault and free registers
  assign capture_en = strobe & ~squashed & ~lock_q;

  // a fresh capture takes priority over a release in the same cycle
  always_comb begin
    lock_d = lock_q;
    if (capture_en)
      lock_d = 1'b1;
    else if (va_rd)
      lock_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_d;
  end

  assert_capture_locks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> lock_q);

  assert_read_unlocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (va_rd && !strobe) |=> !lock_q);

  assert_lock_only_on_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(strobe && !squashed));

endmodule

// File: rtl/mmf_pte_former.sv
module mmf_pte_former #(
  parameter int VPN_W      = 30,
  parameter int FMT_W      = 64,
  parameter int ENT_SHIFT  = 3
) (
  input  logic [VPN_W-1:0] vpn,
  input  logic [FMT_W-1:0] base,
  output logic [FMT_W-1:0] pte_addr
);

  localparam int SCALED_W = VPN_W + ENT_SHIFT;

  function automatic logic [FMT_W-1:0] form(input logic [VPN_W-1:0] v,
                                             input logic [FMT_W-1:0] b);
    logic [SCALED_W-1:0] scaled;
    scaled = SCALED_W'(v) << ENT_SHIFT;
    return b | FMT_W'(scaled);
  endfunction

  assign pte_addr = form(vpn, base);

endmodule

// File: rtl/mmf_capture_regs.sv
module mmf_capture_regs #(
  parameter int VA_W   = 43,
  parameter int STAT_W = 17,
  parameter int FMT_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_en,
  input  logic [VA_W-1:0]   va_in,
  input  logic [STAT_W-1:0] stat_in,
  input  logic [FMT_W-1:0]  fmt_in,
  output logic [VA_W-1:0]   va_q,
  output logic [STAT_W-1:0] stat_q,
  output logic [FMT_W-1:0]  fmt_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q   <= '0;
      stat_q <= '0;
      fmt_q  <= '0;
    end else if (capture_en) begin
      va_q   <= va_in;
      stat_q <= stat_in;
      fmt_q  <= fmt_in;
    end
  end

  assert_hold_without_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_en |=> ($stable(va_q) && $stable(stat_q) && $stable(fmt_q)));

  assert_va_loaded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> (va_q == $past(va_in)));

endmodule

// File: rtl/mmfault_capture.sv
module mmfault_capture #(
  parameter int VA_W      = 43,
  parameter int PG_W      = 13,
  parameter int FMT_W     = 64,
  parameter int ENT_SHIFT = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flt_strobe,
  input  logic [VA_W-1:0]           flt_vaddr,
  input  logic [5:0]                flt_flags,
  input  logic [5:0]                flt_opcode,
  input  logic [4:0]                flt_dest,
  input  logic                      flt_squashed,
  input  logic [FMT_W-1:0]          pt_base,
  input  logic                      va_rd,
  output logic [VA_W-1:0]           va_reg,
  output logic [mmf_pkg::STAT_W-1:0] stat_reg,
  output logic [FMT_W-1:0]          pte_addr_reg
);
  import mmf_pkg::*;

  localparam int VPN_W = VA_W - PG_W;

  // named internal events for the checks below
  logic                capture_en;
  logic                lock_q;
  fault_info_t         info;
  logic [STAT_W-1:0]   stat_word;
  logic [FMT_W-1:0]    pte_word;

  assign info.opc   = flt_opcode;
  assign info.rnum  = flt_dest;
  assign info.flags = flt_flags;
  assign stat_word  = pack_status(info);

  mmf_lock_ctl u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (flt_strobe),
    .squashed   (flt_squashed),
    .va_rd      (va_rd),
    .capture_en (capture_en),
    .lock_q     (lock_q)
  );

  mmf_pte_former #(
    .VPN_W     (VPN_W),
    .FMT_W     (FMT_W),
    .ENT_SHIFT (ENT_SHIFT)
  ) u_form (
    .vpn      (flt_vaddr[VA_W-1:PG_W]),
    .base     (pt_base),
    .pte_addr (pte_word)
  );

  mmf_capture_regs #(
    .VA_W   (VA_W),
    .STAT_W (STAT_W),
    .FMT_W  (FMT_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_en (capture_en),
    .va_in      (flt_vaddr),
    .stat_in    (stat_word),
    .fmt_in     (pte_word),
    .va_q       (va_reg),
    .stat_q     (stat_reg),
    .fmt_q      (pte_addr_reg)
  );

  assert_squash_no_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_squashed && !lock_q) |=> ($stable(va_reg) && !lock_q));

  assert_locked_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && flt_strobe) |=> $stable(va_reg));

  assert_status_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> (stat_reg[16:11] == $past(flt_opcode) &&
                    stat_reg[10:6]  == $past(flt_dest) &&
                    stat_reg[5:0]   == $past(flt_flags)));

  assert_pte_low_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> (pte_addr_reg[ENT_SHIFT-1:0] == $past(pt_base[ENT_SHIFT-1:0])));

endmodule

// File: tb/test_mmfault_capture.sv
module test_mmfault_capture;

  localparam int VA_W  = 43;
  localparam int FMT_W = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              flt_strobe = 1'b0;
  logic [VA_W-1:0]   flt_vaddr = '0;
  logic [5:0]        flt_flags = '0;
  logic [5:0]        flt_opcode = '0;
  logic [4:0]        flt_dest = '0;
  logic              flt_squashed = 1'b0;
  logic [FMT_W-1:0]  pt_base = '0;
  logic              va_rd = 1'b0;
  logic [VA_W-1:0]   va_reg;
  logic [16:0]       stat_reg;
  logic [FMT_W-1:0]  pte_addr_reg;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  mmfault_capture i_mmfault_capture (
    .clk(clk), .rst_n(rst_n), .flt_strobe(flt_strobe), .flt_vaddr(flt_vaddr),
    .flt_flags(flt_flags), .flt_opcode(flt_opcode), .flt_dest(flt_dest),
    .flt_squashed(flt_squashed), .pt_base(pt_base), .va_rd(va_rd),
    .va_reg(va_reg), .stat_reg(stat_reg), .pte_addr_reg(pte_addr_reg)
  );

  // expected values, written from the requirements
  function automatic logic [16:0] exp_stat(input logic [5:0] op, input logic [4:0] rd,
                                           input logic [5:0] fl);
    return {op, rd, fl};
  endfunction

  function automatic logic [63:0] exp_pte(input logic [VA_W-1:0] va, input logic [63:0] pt);
    return pt | (64'(va[VA_W-1:13]) * 64'd8);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: drive after the falling edge, release just after the rising edge
  task automatic step(input logic s, input logic [VA_W-1:0] va, input logic [5:0] fl,
                      input logic [5:0] op, input logic [4:0] rd, input logic sq,
                      input logic [63:0] pt, input logic rdv);
    @(negedge clk);
    flt_strobe = s; flt_vaddr = va; flt_flags = fl; flt_opcode = op;
    flt_dest = rd; flt_squashed = sq; pt_base = pt; va_rd = rdv;
    @(posedge clk);
    #1;
    flt_strobe = 1'b0; flt_squashed = 1'b0; va_rd = 1'b0;
  endtask

  task automatic fault(input logic [VA_W-1:0] va, input logic [5:0] fl,
                       input logic [5:0] op, input logic [4:0] rd, input logic [63:0] pt);
    step(1'b1, va, fl, op, rd, 1'b0, pt, 1'b0);
  endtask

  task automatic read_va();
    step(1'b0, '0, '0, '0, '0, 1'b0, '0, 1'b1);
  endtask

  task automatic expect_all(input string req, input logic [VA_W-1:0] va, input logic [5:0] fl,
                            input logic [5:0] op, input logic [4:0] rd, input logic [63:0] pt);
    chk(req, 64'(va_reg), 64'(va));
    chk(req, 64'(stat_reg), 64'(exp_stat(op, rd, fl)));
    chk(req, pte_addr_reg, exp_pte(va, pt));
  endtask

  localparam logic [VA_W-1:0] VA_A = 43'h123_4567_89AB;
  localparam logic [VA_W-1:0] VA_B = 43'h0AB_CDEF_0123;
  localparam logic [VA_W-1:0] VA_C = 43'h555_5555_5555;
  localparam logic [63:0]     PT1  = 64'h0000_0200_0000_0000;

  task automatic t_reset();
    @(negedge clk);
    chk("R1 va", 64'(va_reg), 64'd0);
    chk("R1 stat", 64'(stat_reg), 64'd0);
    chk("R1 pte", pte_addr_reg, 64'd0);
    // first strobe after reset must be taken: lock starts clear
    fault(VA_A, 6'b010001, 6'h2C, 5'd7, PT1);
    expect_all("R1 R10 R2 R3 R4 first capture", VA_A, 6'b010001, 6'h2C, 5'd7, PT1);
  endtask

  task automatic t_locked();
    fault(VA_B, 6'b000010, 6'h11, 5'd3, PT1);
    expect_all("R6 later fault ignored", VA_A, 6'b010001, 6'h2C, 5'd7, PT1);
    // read together with a fault while frozen: fault dropped, lock released
    step(1'b1, VA_B, 6'b000010, 6'h11, 5'd3, 1'b0, PT1, 1'b1);
    expect_all("R8 fault during releasing read", VA_A, 6'b010001, 6'h2C, 5'd7, PT1);
    fault(VA_C, 6'b100001, 6'h3F, 5'd31, PT1);
    expect_all("R7 capture after read", VA_C, 6'b100001, 6'h3F, 5'd31, PT1);
  endtask

  task automatic t_next_cycle();
    read_va();
    fault(VA_B, 6'b001000, 6'h05, 5'd12, PT1);
    expect_all("R7 capture in cycle right after read", VA_B, 6'b001000, 6'h05, 5'd12, PT1);
  endtask

  task automatic t_squash();
    read_va();
    step(1'b1, VA_A, 6'b000100, 6'h01, 5'd1, 1'b1, PT1, 1'b0);
    expect_all("R5 squashed fault no change", VA_B, 6'b001000, 6'h05, 5'd12, PT1);
    fault(VA_C, 6'b000100, 6'h01, 5'd1, 64'h0);
    expect_all("R5 squash left registers unfrozen", VA_C, 6'b000100, 6'h01, 5'd1, 64'h0);
  endtask

  task automatic t_same_cycle_unlocked();
    read_va();
    step(1'b1, VA_A, 6'b010000, 6'h20, 5'd16, 1'b0, PT1, 1'b1);
    expect_all("R9 capture with read when unfrozen", VA_A, 6'b010000, 6'h20, 5'd16, PT1);
    fault(VA_B, 6'b000001, 6'h02, 5'd2, PT1);
    expect_all("R9 frozen after same-cycle capture", VA_A, 6'b010000, 6'h20, 5'd16, PT1);
  endtask

  task automatic t_edges();
    logic [63:0] pt_ovl;
    pt_ovl = 64'hFFFF_0000_0000_FFFF;
    read_va();
    fault('1, 6'b111111, 6'h3F, 5'h1F, pt_ovl);
    expect_all("R4 R2 all ones with overlapping base", '1, 6'b111111, 6'h3F, 5'h1F, pt_ovl);
    read_va();
    fault(43'h000_0000_1FFF, 6'b100000, 6'h00, 5'd0, 64'h0);
    expect_all("R4 offset only gives zero page", 43'h000_0000_1FFF, 6'b100000, 6'h00, 5'd0, 64'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_locked();
    t_next_cycle();
    t_squash();
    t_same_cycle_unlocked();
    t_edges();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule